// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

This block gathers interrupt requests from the units of a peripheral companion chip and presents them to the host as one interrupt line. A 16-bit first-level status word holds one bit per unit. A first-level mask gates that word, and the host line is high whenever any unmasked first-level bit is set. Units with several causes of their own (keyboard, touch panel, audio, GPIO) have second-level status and mask registers. For each such unit, the OR of its enabled second-level causes forms its first-level bit.

Second-level status bits are sticky. They capture the rising edge of each cause request and hold it until software writes a 1 to that bit. The GPIO unit has 32 causes, split across a low register pair and a high register pair. Software reaches every register through a simple 16-bit word interface and updates masks by read-modify-write.

Top module: `casc_irq_ctrl`

## Requirements
- R1: After reset, and after any later reset, all mask and status registers read 0 and `irq_o` is low.
- R2: First-level status (address 0, read-only) is built as follows:
  - Bits 0, 1, 2, 3, 4, 9, 10 and 13 follow the matching `unit_req_i` bits as levels.
  - Bit 5 comes from the touch panel, bit 6 from audio, bit 7 from the keyboard and bit 8 from GPIO.
  - Bits 11, 12, 14 and 15 read 0.
  - `unit_req_i` bits 5 to 8, 11, 12, 14 and 15 are ignored.
- R3: `irq_o` is registered. It goes high one clock after (first-level status AND first-level mask) becomes nonzero, and goes low one clock after it becomes zero.
- R4: The first-level mask is at address 1. A 1 enables a source. Bits 11, 12, 14 and 15 read 0 and ignore writes.
- R5: A second-level status bit sets on a rising edge of its cause request and stays set after the request falls.
- R6: Writing 1 to a second-level status bit clears it, and writing 0 leaves it unchanged. If a rising edge arrives in the same cycle as the clear, the bit ends set.
- R7: The first-level bit of a cascaded unit is the OR of (second-level status AND second-level mask) for that unit. It follows mask changes in the same cycle.
- R8: The keyboard status is at address 2 and its mask at address 3. Bit 0 is scan complete, bit 1 is data ready and bit 2 is data lost. Bits 3 to 15 read 0 and ignore writes.
- R9: The GPIO causes are split over two register pairs:
  - Causes 15..0 use status at address 8 and mask at address 9.
  - Causes 31..16 use status at address 10 and mask at address 11.
  - An enabled cause in either half sets first-level bit 8.
- R10: Addresses 12 to 15 read 0, and writes to them change no register.
- R11: A request held high sets its status bit only once. Clearing the bit while the request stays high leaves it clear.
- R12: The touch-panel status is at address 4 and its mask at address 5. The audio status is at address 6 and its mask at address 7. Each has `TP_CAUSES` or `AUD_CAUSES` bits (default 4), and the bits above those read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| unit_req_i | input | 16 | Level requests of units without second-level registers, by first-level bit |
| kbd_req_i | input | KBD_CAUSES | Keyboard cause requests |
| tp_req_i | input | TP_CAUSES | Touch-panel cause requests |
| aud_req_i | input | AUD_CAUSES | Audio cause requests |
| gpio_req_i | input | 32 | GPIO cause requests |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational from address |
| irq_o | output | 1 | Registered host interrupt |

## Verification
The hardest case to reach from the ports is a rising cause request that lands in the same clock as a write-one-to-clear of that same bit. The bench reaches it by raising the keyboard request at the same falling edge at which it starts the clear write, so both reach the bank on one rising edge. A held request followed by a clear is the other corner case. The bench checks that this clear sticks while the request stays high, and that the GPIO high half reaches first-level bit 8 only through its own mask.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int unsigned DW = 16;
  localparam int unsigned AW = 4;
  localparam int unsigned NBANK = 5;

  // first-level bit positions
  localparam int unsigned L1_USB    = 0;
  localparam int unsigned L1_CARD2  = 1;
  localparam int unsigned L1_CARD1  = 2;
  localparam int unsigned L1_PS2B   = 3;
  localparam int unsigned L1_PS2A   = 4;
  localparam int unsigned L1_TP     = 5;
  localparam int unsigned L1_AUD    = 6;
  localparam int unsigned L1_KBD    = 7;
  localparam int unsigned L1_GPIO   = 8;
  localparam int unsigned L1_AC97   = 9;
  localparam int unsigned L1_AC97B  = 10;
  localparam int unsigned L1_TPDOZE = 13;

  localparam logic [DW-1:0] L1_DIRECT =
      (DW'(1) << L1_USB)  | (DW'(1) << L1_CARD2) | (DW'(1) << L1_CARD1) |
      (DW'(1) << L1_PS2B) | (DW'(1) << L1_PS2A)  | (DW'(1) << L1_AC97)  |
      (DW'(1) << L1_AC97B) | (DW'(1) << L1_TPDOZE);
  localparam logic [DW-1:0] L1_CASCADE =
      (DW'(1) << L1_TP) | (DW'(1) << L1_AUD) | (DW'(1) << L1_KBD) | (DW'(1) << L1_GPIO);
  localparam logic [DW-1:0] L1_VALID = L1_DIRECT | L1_CASCADE;

  // bank order: 0 kbd, 1 tp, 2 aud, 3 gpio low, 4 gpio high
  localparam logic [AW-1:0] ADDR_L1_STAT = 4'd0;
  localparam logic [AW-1:0] ADDR_L1_MASK = 4'd1;

  function automatic logic [AW-1:0] bank_stat_addr(int unsigned b);
    return AW'(2 + 2 * b);
  endfunction

  function automatic logic [AW-1:0] bank_mask_addr(int unsigned b);
    return AW'(3 + 2 * b);
  endfunction
endpackage

// File: rtl/icu_cause_bank.sv
module icu_cause_bank
  import icu_pkg::*;
#(
  parameter logic [DW-1:0] IMPL = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] req_i,
  input  logic          clr_we_i,
  input  logic          mask_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] stat_o,
  output logic [DW-1:0] mask_o,
  output logic          pend_o
);
  logic [DW-1:0] req_q, stat_q, mask_q;
  logic [DW-1:0] rise, clr;

  assign rise = req_i & ~req_q & IMPL;
  assign clr  = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      req_q  <= req_i & IMPL;
      stat_q <= ((stat_q & ~clr) | rise) & IMPL;
      if (mask_we_i) mask_q <= wdata_i & IMPL;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign pend_o = |(stat_q & mask_q);

  assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q != '0) |=> ((($past(stat_q) & ~$past(clr)) & ~stat_q) == '0));

  assert_w1c_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((stat_q & $past(wdata_i & ~rise)) == '0));

  assert_edge_only_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != '0) |=> ((stat_q & ~$past(stat_q) & ~$past(req_i & ~req_q)) == '0));
endmodule

// File: rtl/icu_root.sv
module icu_root
  import icu_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] src_i,
  input  logic          mask_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] mask_o,
  output logic          irq_o
);
  logic [DW-1:0] mask_q;
  logic          irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= wdata_i & L1_VALID;
      irq_q <= |(src_i & mask_q);
    end
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  assert_irq_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((src_i & mask_q) != '0) |=> irq_o);

  assert_irq_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((src_i & mask_q) == '0) |=> !irq_o);

  assert_mask_rsvd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> ((mask_q & ~L1_VALID) == '0));
endmodule

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl
  import icu_pkg::*;
#(
  parameter int unsigned KBD_CAUSES = 3,
  parameter int unsigned TP_CAUSES  = 4,
  parameter int unsigned AUD_CAUSES = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [DW-1:0]         unit_req_i,
  input  logic [KBD_CAUSES-1:0] kbd_req_i,
  input  logic [TP_CAUSES-1:0]  tp_req_i,
  input  logic [AUD_CAUSES-1:0] aud_req_i,
  input  logic [2*DW-1:0]       gpio_req_i,
  input  logic                  reg_we_i,
  input  logic [AW-1:0]         reg_addr_i,
  input  logic [DW-1:0]         reg_wdata_i,
  output logic [DW-1:0]         reg_rdata_o,
  output logic                  irq_o
);
  function automatic logic [DW-1:0] bank_impl(int unsigned b);
    case (b)
      0:       return DW'((32'd1 << KBD_CAUSES) - 1);
      1:       return DW'((32'd1 << TP_CAUSES) - 1);
      2:       return DW'((32'd1 << AUD_CAUSES) - 1);
      default: return '1;
    endcase
  endfunction

  logic [DW-1:0] bank_req  [NBANK];
  logic [DW-1:0] bank_stat [NBANK];
  logic [DW-1:0] bank_mask [NBANK];
  logic [NBANK-1:0] bank_pend;
  logic [DW-1:0] l1_stat, l1_mask;

  assign bank_req[0] = DW'(kbd_req_i);
  assign bank_req[1] = DW'(tp_req_i);
  assign bank_req[2] = DW'(aud_req_i);
  assign bank_req[3] = gpio_req_i[DW-1:0];
  assign bank_req[4] = gpio_req_i[2*DW-1:DW];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    icu_cause_bank #(.IMPL(bank_impl(g))) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_i     (bank_req[g]),
      .clr_we_i  (reg_we_i && reg_addr_i == bank_stat_addr(g)),
      .mask_we_i (reg_we_i && reg_addr_i == bank_mask_addr(g)),
      .wdata_i   (reg_wdata_i),
      .stat_o    (bank_stat[g]),
      .mask_o    (bank_mask[g]),
      .pend_o    (bank_pend[g])
    );
  end

  always_comb begin
    l1_stat          = unit_req_i & L1_DIRECT;
    l1_stat[L1_KBD]  = bank_pend[0];
    l1_stat[L1_TP]   = bank_pend[1];
    l1_stat[L1_AUD]  = bank_pend[2];
    l1_stat[L1_GPIO] = bank_pend[3] | bank_pend[4];
  end

  icu_root u_root (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_i     (l1_stat),
    .mask_we_i (reg_we_i && reg_addr_i == ADDR_L1_MASK),
    .wdata_i   (reg_wdata_i),
    .mask_o    (l1_mask),
    .irq_o     (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_L1_STAT) reg_rdata_o = l1_stat;
    if (reg_addr_i == ADDR_L1_MASK) reg_rdata_o = l1_mask;
    for (int b = 0; b < NBANK; b++) begin
      if (reg_addr_i == bank_stat_addr(b)) reg_rdata_o = bank_stat[b];
      if (reg_addr_i == bank_mask_addr(b)) reg_rdata_o = bank_mask[b];
    end
  end

  assert_kbd_cascade_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((bank_stat[0] & bank_mask[0]) != '0) |-> l1_stat[L1_KBD]);

  assert_gpio_cascade_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((bank_stat[4] & bank_mask[4]) != '0) |-> l1_stat[L1_GPIO]);

  assert_unmapped_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i >= AW'(2 + 2 * NBANK)) |-> (reg_rdata_o == '0));

  assert_l1_rsvd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((l1_stat & ~L1_VALID) == '0));
endmodule

// File: tb/casc_irq_ctrl_tb.sv
`timescale 1ns/1ps
module casc_irq_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] unit_req_i = '0;
  logic [2:0]  kbd_req_i = '0;
  logic [3:0]  tp_req_i = '0;
  logic [3:0]  aud_req_i = '0;
  logic [31:0] gpio_req_i = '0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        irq_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  casc_irq_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .unit_req_i(unit_req_i),
    .kbd_req_i(kbd_req_i), .tp_req_i(tp_req_i), .aud_req_i(aud_req_i),
    .gpio_req_i(gpio_req_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [15:0] req;
    logic [15:0] mask;
    logic [15:0] stat;
    logic [15:0] mrb;
    logic        irq;
  } vec_t;

  // direct first-level bits, mask readback, irq
  localparam vec_t VEC [8] = '{
    '{16'hFFFF, 16'hFFFF, 16'h261F, 16'h27FF, 1'b1},
    '{16'h0001, 16'h0000, 16'h0001, 16'h0000, 1'b0},
    '{16'h0001, 16'h0001, 16'h0001, 16'h0001, 1'b1},
    '{16'h01E0, 16'hFFFF, 16'h0000, 16'h27FF, 1'b0},
    '{16'h2000, 16'h2000, 16'h2000, 16'h2000, 1'b1},
    '{16'h0400, 16'h0200, 16'h0400, 16'h0200, 1'b0},
    '{16'hD800, 16'hFFFF, 16'h0000, 16'h27FF, 1'b0},
    '{16'h0010, 16'h0010, 16'h0010, 16'h0010, 1'b1}
  };

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    tick();
    reg_we_i = 1'b0;
  endtask

  task automatic rd_check(string tag, logic [3:0] a, logic [15:0] exp);
    reg_addr_i = a;
    #0.5;
    check(tag, 32'(reg_rdata_o), 32'(exp));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    // R1: reset state
    check("R1 irq", 32'(irq_o), 0);
    for (int a = 0; a < 12; a++) rd_check("R1 reg", 4'(a), 16'h0000);

    // R2 R3 R4: table walk
    for (int i = 0; i < 8; i++) begin
      unit_req_i = VEC[i].req;
      wr(4'd1, VEC[i].mask);
      tick();
      rd_check("R2 l1 stat", 4'd0, VEC[i].stat);
      rd_check("R4 l1 mask", 4'd1, VEC[i].mrb);
      check("R3 irq", 32'(irq_o), 32'(VEC[i].irq));
    end
    unit_req_i = '0;
    wr(4'd1, 16'h0000);
    tick();
    check("R3 irq low", 32'(irq_o), 0);

    // keyboard bank
    wr(4'd3, 16'hFFFF);
    rd_check("R8 kbd mask rsvd", 4'd3, 16'h0007);
    kbd_req_i = 3'b010; tick(); kbd_req_i = '0; tick();
    rd_check("R5 sticky", 4'd2, 16'h0002);
    rd_check("R7 cascade kbd", 4'd0, 16'h0080);
    check("R4 masked no irq", 32'(irq_o), 0);
    wr(4'd1, 16'h0080);
    check("R3 registered", 32'(irq_o), 0);
    tick();
    check("R3 irq set", 32'(irq_o), 1);
    wr(4'd3, 16'h0001);
    rd_check("R7 l2 mask gates", 4'd0, 16'h0000);
    tick();
    check("R3 irq clr", 32'(irq_o), 0);
    wr(4'd3, 16'hFFFF);
    wr(4'd2, 16'h0000);
    rd_check("R6 write zero", 4'd2, 16'h0002);
    wr(4'd2, 16'h0002);
    rd_check("R6 w1c", 4'd2, 16'h0000);

    // R11: held level
    kbd_req_i = 3'b001; tick();
    rd_check("R11 set", 4'd2, 16'h0001);
    wr(4'd2, 16'h0001);
    tick(); tick();
    rd_check("R11 held no reset", 4'd2, 16'h0000);
    kbd_req_i = '0; tick();

    // R6: rise and clear on the same edge
    kbd_req_i = 3'b100;
    wr(4'd2, 16'h0004);
    rd_check("R6 set wins", 4'd2, 16'h0004);
    kbd_req_i = '0;
    wr(4'd2, 16'hFFFF);
    rd_check("R6 clear all", 4'd2, 16'h0000);

    // R9: gpio halves
    wr(4'd9, 16'h0001);
    wr(4'd11, 16'h8000);
    gpio_req_i = 32'h8000_0000; tick();
    rd_check("R9 gpio high stat", 4'd10, 16'h8000);
    rd_check("R9 gpio low stat", 4'd8, 16'h0000);
    rd_check("R9 gpio l1 via high", 4'd0, 16'h0100);
    gpio_req_i = '0;
    wr(4'd10, 16'h8000);
    gpio_req_i = 32'h0000_0001; tick();
    rd_check("R9 gpio low stat2", 4'd8, 16'h0001);
    rd_check("R9 gpio l1 via low", 4'd0, 16'h0100);
    gpio_req_i = '0;
    wr(4'd8, 16'h0001);
    gpio_req_i = 32'h0001_0000; tick();
    rd_check("R9 gpio high stat3", 4'd10, 16'h0001);
    rd_check("R7 gpio unmasked", 4'd0, 16'h0000);
    gpio_req_i = '0;
    wr(4'd10, 16'hFFFF);

    // R12: touch panel and audio
    wr(4'd5, 16'hFFFF);
    wr(4'd7, 16'hFFFF);
    rd_check("R12 tp mask", 4'd5, 16'h000F);
    rd_check("R12 aud mask", 4'd7, 16'h000F);
    tp_req_i = 4'b0001; aud_req_i = 4'b1000; tick();
    rd_check("R12 tp stat", 4'd4, 16'h0001);
    rd_check("R12 aud stat", 4'd6, 16'h0008);
    rd_check("R2 cascade tp aud", 4'd0, 16'h0060);

    // R10: unmapped addresses
    wr(4'd12, 16'hFFFF);
    wr(4'd15, 16'hFFFF);
    rd_check("R10 read 12", 4'd12, 16'h0000);
    rd_check("R10 read 15", 4'd15, 16'h0000);
    rd_check("R10 l1 mask kept", 4'd1, 16'h0080);
    rd_check("R10 tp mask kept", 4'd5, 16'h000F);

    // R1: reset in mid-run
    tp_req_i = '0; aud_req_i = '0;
    wr(4'd1, 16'hFFFF);
    tick();
    rst_ni = 1'b0;
    #0.5;
    check("R1 irq after reset", 32'(irq_o), 0);
    rd_check("R1 l1 mask", 4'd1, 16'h0000);
    rd_check("R1 tp stat", 4'd4, 16'h0000);
    rd_check("R1 tp mask", 4'd5, 16'h0000);
    tick();
    rst_ni = 1'b1;
    tick();

    done = 1'b1;
    finish_run();
  end
endmodule